// File: doc/BRIEF.md
# Asynchronous Page-Mode Read Sequencer

This block runs read bursts against an asynchronous page-mode flash or ROM on an external memory bus. A requester gives a start word address, a word count and a set of timing settings. These settings are the page size, a wait count for the first word of each page, a wait count for later words in the same page, and a divide ratio for the reference clock. The block then holds chip select and output enable low and steps the address one word at a time. It latches each returned word after the programmed delay and hands it on with a one-cycle valid strobe.

All timing is counted in reference periods. A reference period is produced by a clock-enable pulse taken from the core clock, not by a derived clock. The first word of a page waits longer than a page hit. When the address wraps into a new page partway through a burst, the block uses the long delay again. The settings are captured when a burst is accepted, so software may change them at any time. The external memory clock output is held low throughout.

Top module: `pagerd_seq`

## Requirements
- R1: After reset, busy is 0, mem_cs_n and mem_oe_n are 1, rd_valid is 0 and mem_addr is 0.
- R2: Divider select 0, 1, 2 and 3 gives a reference period of 1, 2, 4 and 6 core cycles. All delays below are that many core cycles per reference period.
- R3: The first word of a burst is latched (first_wait + 2) reference periods after the core clock edge that accepts start. first_wait is a 4-bit value, 0 to 15.
- R4: A word in the same page as the word before it is latched (page_wait + 1) reference periods after that word. page_wait is a 4-bit value, 0 to 15.
- R5: Page select 0 gives 4 words per page, 1 gives 8, and 2 or 3 give 16. A word whose address has its low log2(page size) bits all zero, reached partway through a burst, waits (first_wait + 2) reference periods.
- R6: mem_addr starts at start_addr and rises by one after each latched word. On each rd_valid pulse, rd_data equals the mem_data that was present for that address.
- R7: During the access phase of a burst, mem_cs_n and mem_oe_n are both 0. mem_addr does not change between latch points.
- R8: After the last word is latched, mem_cs_n and mem_oe_n are 1 for exactly one reference period, and then busy returns to 0.
- R9: The settings are sampled when start is accepted. Changing them during a burst does not alter that burst's timing.
- R10: start is ignored while busy is 1, and it is ignored when word_count is 0.
- R11: mem_clk is 0 at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a burst (taken when idle) |
| start_addr | input | AW | First word address |
| word_count | input | CW | Number of words in the burst |
| cfg_page_sel | input | 2 | Page size select |
| cfg_first_wait | input | 4 | First-word-of-page wait setting |
| cfg_page_wait | input | 4 | Page-hit wait setting |
| cfg_div_sel | input | 2 | Reference divider select |
| busy | output | 1 | Burst in progress, including recovery |
| mem_cs_n | output | 1 | Memory chip select, active low |
| mem_oe_n | output | 1 | Memory output enable, active low |
| mem_clk | output | 1 | Memory clock, held low |
| mem_addr | output | AW | Word address to memory |
| mem_data | input | DW | Read data from memory |
| rd_data | output | DW | Latched word |
| rd_valid | output | 1 | One-cycle strobe for rd_data |

## Verification
The bench measures the gap in core cycles between rd_valid pulses. A design that counted from the wrong edge, or that skipped the divider, would be off by a multiple of the reference period. Bursts that start just below a page end, with every page size, catch a sequencer that compares the wrong low address bits, or that reuses the page-hit delay after the wrap. Other bursts change the settings and pulse start in the middle of a burst; a design that read the live settings would stretch or shrink later gaps, and one that re-armed on start would jump the address. The extremes are also covered: divide-by-6 with both waits at 15, a single-word burst, and a zero count. These expose off-by-one errors in the recovery period and in the end of the burst.

// File: rtl/pagerd_pkg.sv
package pagerd_pkg;

   localparam int WAIT_W = 4;
   localparam int NEED_W = WAIT_W + 1;
   localparam int DIV_W  = 3;
   localparam int PAGE_LOG_MAX = 4;

   typedef enum logic [1:0] {
      ST_IDLE    = 2'd0,
      ST_ACCESS  = 2'd1,
      ST_RECOVER = 2'd2
   } seq_state_t;

   function automatic logic [DIV_W-1:0] div_ratio(input logic [1:0] sel);
      case (sel)
         2'd0:    return 3'd1;
         2'd1:    return 3'd2;
         2'd2:    return 3'd4;
         default: return 3'd6;
      endcase
   endfunction

   function automatic logic [2:0] page_log(input logic [1:0] sel);
      case (sel)
         2'd0:    return 3'd2;
         2'd1:    return 3'd3;
         default: return 3'd4;
      endcase
   endfunction

   function automatic logic [NEED_W-1:0] first_need(input logic [WAIT_W-1:0] w);
      return {1'b0, w} + NEED_W'(2);
   endfunction

   function automatic logic [NEED_W-1:0] hit_need(input logic [WAIT_W-1:0] w);
      return {1'b0, w} + NEED_W'(1);
   endfunction

endpackage

// File: rtl/pagerd_tick.sv
module pagerd_tick #(
   parameter int CNT_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             restart,
   input  logic [CNT_W-1:0] ratio,
   output logic             tick
);
   logic [CNT_W-1:0] cnt;

   assign tick = (cnt == ratio - CNT_W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         cnt <= '0;
      else if (restart || tick)
         cnt <= '0;
      else
         cnt <= cnt + CNT_W'(1);
   end
endmodule

// File: rtl/pagerd_wait.sv
module pagerd_wait #(
   parameter int W = 5
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         load,
   input  logic [W-1:0] load_val,
   input  logic         tick,
   output logic         expire
);
   logic [W-1:0] left;

   assign expire = tick && (left == W'(1));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)
         left <= '0;
      else if (load)
         left <= load_val;
      else if (tick && left != '0)
         left <= left - W'(1);
   end
endmodule

// File: rtl/pagerd_pgdet.sv
module pagerd_pgdet #(
   parameter int AW       = 24,
   parameter int LOG_MAX  = 4
) (
   input  logic [AW-1:0] addr,
   input  logic [2:0]    log_size,
   output logic          at_page_start
);
   logic [LOG_MAX-1:0] hit_bits;

   for (genvar i = 0; i < LOG_MAX; i++) begin : g_bit
      assign hit_bits[i] = addr[i] && (3'(i) < log_size);
   end

   assign at_page_start = (hit_bits == '0);
endmodule

// File: rtl/pagerd_seq.sv
module pagerd_seq
   import pagerd_pkg::*;
#(
   parameter int AW = 24,
   parameter int DW = 16,
   parameter int CW = 8
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic                 start,
   input  logic [AW-1:0]        start_addr,
   input  logic [CW-1:0]        word_count,
   input  logic [1:0]           cfg_page_sel,
   input  logic [WAIT_W-1:0]    cfg_first_wait,
   input  logic [WAIT_W-1:0]    cfg_page_wait,
   input  logic [1:0]           cfg_div_sel,
   output logic                 busy,
   output logic                 mem_cs_n,
   output logic                 mem_oe_n,
   output logic                 mem_clk,
   output logic [AW-1:0]        mem_addr,
   input  logic [DW-1:0]        mem_data,
   output logic [DW-1:0]        rd_data,
   output logic                 rd_valid
);
   if (AW < PAGE_LOG_MAX + 1) begin : g_bad_aw
      $error("pagerd_seq: AW too small for the largest page");
   end
   if (DW < 1 || CW < 1) begin : g_bad_w
      $error("pagerd_seq: DW and CW must be positive");
   end

   seq_state_t           state;
   logic [WAIT_W-1:0]    hold_first;
   logic [WAIT_W-1:0]    hold_hit;
   logic [2:0]           hold_log;
   logic [DIV_W-1:0]     hold_ratio;
   logic [CW-1:0]        remain;

   logic                 accept;
   logic                 tick;
   logic                 expire;
   logic                 latch_now;
   logic                 last_word;
   logic                 next_is_first;
   logic                 wait_load;
   logic [NEED_W-1:0]    wait_val;
   logic [AW-1:0]        next_addr;

   assign accept    = start && (state == ST_IDLE) && (word_count != '0);
   assign latch_now = (state == ST_ACCESS) && expire;
   assign last_word = (remain == CW'(1));
   assign next_addr = mem_addr + AW'(1);

   pagerd_tick #(.CNT_W(DIV_W)) u_tick (
      .clk     (clk),
      .rst_n   (rst_n),
      .restart (accept),
      .ratio   (hold_ratio),
      .tick    (tick)
   );

   pagerd_pgdet #(.AW(AW), .LOG_MAX(PAGE_LOG_MAX)) u_pgdet (
      .addr          (next_addr),
      .log_size      (hold_log),
      .at_page_start (next_is_first)
   );

   always_comb begin
      wait_load = accept || (latch_now && !last_word);
      if (accept)
         wait_val = first_need(cfg_first_wait);
      else if (next_is_first)
         wait_val = first_need(hold_first);
      else
         wait_val = hit_need(hold_hit);
   end

   pagerd_wait #(.W(NEED_W)) u_wait (
      .clk      (clk),
      .rst_n    (rst_n),
      .load     (wait_load),
      .load_val (wait_val),
      .tick     (tick),
      .expire   (expire)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state      <= ST_IDLE;
         hold_first <= '0;
         hold_hit   <= '0;
         hold_log   <= 3'd2;
         hold_ratio <= 3'd1;
         remain     <= '0;
         mem_addr   <= '0;
         rd_data    <= '0;
         rd_valid   <= 1'b0;
      end else begin
         rd_valid <= 1'b0;
         case (state)
            ST_IDLE: begin
               if (accept) begin
                  state      <= ST_ACCESS;
                  hold_first <= cfg_first_wait;
                  hold_hit   <= cfg_page_wait;
                  hold_log   <= page_log(cfg_page_sel);
                  hold_ratio <= div_ratio(cfg_div_sel);
                  remain     <= word_count;
                  mem_addr   <= start_addr;
               end
            end
            ST_ACCESS: begin
               if (latch_now) begin
                  rd_data  <= mem_data;
                  rd_valid <= 1'b1;
                  mem_addr <= next_addr;
                  remain   <= remain - CW'(1);
                  if (last_word)
                     state <= ST_RECOVER;
               end
            end
            ST_RECOVER: begin
               if (tick)
                  state <= ST_IDLE;
            end
            default: state <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (state != ST_IDLE);
   assign mem_cs_n = (state != ST_ACCESS);
   assign mem_oe_n = !(state == ST_ACCESS);
   assign mem_clk  = 1'b0;

endmodule

// File: rtl/pagerd_chk.sv
module pagerd_chk #(
   parameter int AW = 24
) (
   input logic          clk,
   input logic          rst_n,
   input logic          busy,
   input logic          mem_cs_n,
   input logic          mem_oe_n,
   input logic [AW-1:0] mem_addr,
   input logic          rd_valid
);
   assert_strobe_pair_R7: assert property (@(posedge clk) disable iff (!rst_n)
      mem_cs_n == mem_oe_n);

   assert_idle_released_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (mem_cs_n && !rd_valid));

   assert_addr_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && !rd_valid) |-> $stable(mem_addr));

   assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_valid && $past(busy)) |-> (mem_addr == $past(mem_addr) + AW'(1)));

   assert_valid_in_burst_R6: assert property (@(posedge clk) disable iff (!rst_n)
      rd_valid |-> busy);

   assert_recover_gap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(busy) |-> (mem_cs_n && $past(mem_cs_n)));
endmodule

bind pagerd_seq pagerd_chk #(.AW(AW)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .busy     (busy),
   .mem_cs_n (mem_cs_n),
   .mem_oe_n (mem_oe_n),
   .mem_addr (mem_addr),
   .rd_valid (rd_valid)
);

// File: tb/sim_pagerd_seq.sv
`timescale 1ns/1ps
module sim_pagerd_seq;
   localparam int AW = 24;
   localparam int DW = 16;
   localparam int CW = 8;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start = 1'b0;
   logic [AW-1:0] start_addr = '0;
   logic [CW-1:0] word_count = '0;
   logic [1:0]    cfg_page_sel = '0;
   logic [3:0]    cfg_first_wait = '0;
   logic [3:0]    cfg_page_wait = '0;
   logic [1:0]    cfg_div_sel = '0;
   logic          busy, mem_cs_n, mem_oe_n, mem_clk, rd_valid;
   logic [AW-1:0] mem_addr;
   logic [DW-1:0] mem_data, rd_data;

   int unsigned cyc = 0;
   int tests = 0;
   int fails = 0;

   always #2.5 clk = ~clk;
   always @(posedge clk) cyc <= cyc + 1;

   function automatic logic [DW-1:0] pat(input logic [AW-1:0] a);
      return a[15:0] ^ 16'h5A3C ^ {a[23:16], 8'h00};
   endfunction

   function automatic int ratio_of(input logic [1:0] s);
      case (s)
         2'd0: return 1;
         2'd1: return 2;
         2'd2: return 4;
         default: return 6;
      endcase
   endfunction

   function automatic int pwords(input logic [1:0] s);
      case (s)
         2'd0: return 4;
         2'd1: return 8;
         default: return 16;
      endcase
   endfunction

   assign mem_data = (!mem_cs_n && !mem_oe_n) ? pat(mem_addr) : 16'h0000;

   pagerd_seq #(.AW(AW), .DW(DW), .CW(CW)) u0 (
      .clk(clk), .rst_n(rst_n), .start(start), .start_addr(start_addr),
      .word_count(word_count), .cfg_page_sel(cfg_page_sel),
      .cfg_first_wait(cfg_first_wait), .cfg_page_wait(cfg_page_wait),
      .cfg_div_sel(cfg_div_sel), .busy(busy), .mem_cs_n(mem_cs_n),
      .mem_oe_n(mem_oe_n), .mem_clk(mem_clk), .mem_addr(mem_addr),
      .mem_data(mem_data), .rd_data(rd_data), .rd_valid(rd_valid));

   task automatic check(input bit ok, input string req, input longint act, input longint exp);
      tests++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic run_burst(input logic [AW-1:0] a, input logic [CW-1:0] n,
                            input logic [1:0] ps, input logic [3:0] fw,
                            input logic [3:0] pw, input logic [1:0] ds,
                            input bit disturb);
      int unsigned t_prev;
      int need;
      int div;
      int mask;
      logic [AW-1:0] ea;
      bit lo_bad;
      int guard;
      @(negedge clk);
      start_addr = a; word_count = n; cfg_page_sel = ps;
      cfg_first_wait = fw; cfg_page_wait = pw; cfg_div_sel = ds;
      start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      check(busy === 1'b1, "R3 burst accepted", busy, 1);
      t_prev = cyc;
      div = ratio_of(ds);
      mask = pwords(ps) - 1;
      if (disturb) begin
         // R9 / R10: new settings and a second start while busy
         cfg_page_sel = ~ps; cfg_first_wait = ~fw; cfg_page_wait = ~pw;
         cfg_div_sel = ~ds; start_addr = a + 24'h000100; word_count = 8'd1;
         start = 1'b1;
         @(negedge clk);
         start = 1'b0;
      end
      ea = a;
      need = fw + 2;
      lo_bad = 1'b0;
      for (int i = 0; i < int'(n); i++) begin
         guard = 0;
         while (!rd_valid && guard < 3000) begin
            if (!rd_valid && (mem_cs_n || mem_oe_n || mem_clk)) lo_bad = 1'b1;
            @(negedge clk);
            guard++;
         end
         if (i == 0)
            check(cyc - t_prev == unsigned'(need * div), "R3/R2 first word gap",
                  cyc - t_prev, need * div);
         else if ((int'(ea) & mask) == 0)
            check(cyc - t_prev == unsigned'(need * div), "R5 new page gap",
                  cyc - t_prev, need * div);
         else
            check(cyc - t_prev == unsigned'(need * div), "R4 page hit gap",
                  cyc - t_prev, need * div);
         if (disturb)
            check(cyc - t_prev == unsigned'(need * div), "R9 settings held", cyc - t_prev, need * div);
         check(rd_data === pat(ea), "R6 data/address", rd_data, pat(ea));
         t_prev = cyc;
         ea = ea + 1;
         need = ((int'(ea) & mask) == 0) ? fw + 2 : pw + 1;
         @(negedge clk);
         if (busy === 1'b0 || i == int'(n) - 1) begin
            // leave the loop position at the latch cycle + 1
         end
      end
      check(!lo_bad, "R7/R11 strobes low, clock low", lo_bad, 0);
      check(mem_cs_n === 1'b1 && mem_oe_n === 1'b1, "R8 strobes released", mem_cs_n, 1);
      guard = 0;
      while (busy && guard < 100) begin
         @(negedge clk);
         guard++;
      end
      check(cyc - t_prev == unsigned'(div), "R8 recovery length", cyc - t_prev, div);
      check(rd_valid === 1'b0 && mem_addr === a + n, "R10 no extra burst", mem_addr, a + n);
      @(negedge clk);
      check(busy === 1'b0, "R10 stays idle", busy, 0);
   endtask

   initial begin
      repeat (3000) @(posedge clk);
      repeat (187000) @(posedge clk);
      fails++;
      tests++;
      $display("FAIL R3 watchdog expired actual=running expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      void'($urandom(32'd20240611));
      repeat (3) @(negedge clk);
      // R1 reset state
      check(busy === 1'b0 && mem_cs_n === 1'b1 && mem_oe_n === 1'b1 &&
            rd_valid === 1'b0 && mem_addr === '0, "R1 reset state", busy, 0);
      check(mem_clk === 1'b0, "R11 clock held low", mem_clk, 0);
      rst_n = 1'b1;
      @(negedge clk);
      check(busy === 1'b0, "R1 idle after reset", busy, 0);

      // 8 words from an aligned address, 8-word pages
      run_burst(24'h000040, 8'd8, 2'd1, 4'd2, 4'd0, 2'd1, 1'b0);
      // page crossing with each page size (R5)
      run_burst(24'h00010E, 8'd6, 2'd0, 4'd3, 4'd1, 2'd0, 1'b0);
      run_burst(24'h000205, 8'd6, 2'd1, 4'd1, 4'd2, 2'd2, 1'b0);
      run_burst(24'h00033C, 8'd8, 2'd2, 4'd0, 4'd0, 2'd1, 1'b0);
      run_burst(24'h00041D, 8'd5, 2'd3, 4'd4, 4'd3, 2'd0, 1'b0);
      // extremes of the waits and divider (R2)
      run_burst(24'h000503, 8'd3, 2'd0, 4'd15, 4'd15, 2'd3, 1'b0);
      run_burst(24'h000600, 8'd4, 2'd0, 4'd0, 4'd0, 2'd0, 1'b0);
      // single word
      run_burst(24'h0007FF, 8'd1, 2'd2, 4'd5, 4'd5, 2'd2, 1'b0);
      // R9 / R10: changes and start during a burst
      run_burst(24'h00080D, 8'd7, 2'd0, 4'd2, 4'd1, 2'd1, 1'b1);

      // R10: zero word count is ignored
      @(negedge clk);
      start_addr = 24'h00ABCD; word_count = 8'd0; start = 1'b1;
      @(negedge clk);
      start = 1'b0;
      repeat (10) @(negedge clk);
      check(busy === 1'b0 && mem_cs_n === 1'b1 && rd_valid === 1'b0,
            "R10 zero count ignored", busy, 0);

      for (int k = 0; k < 25; k++) begin
         run_burst(AW'($urandom_range(0, 24'hFFFF00)), CW'($urandom_range(1, 20)),
                   2'($urandom_range(0, 3)), 4'($urandom_range(0, 15)),
                   4'($urandom_range(0, 15)), 2'($urandom_range(0, 3)),
                   ($urandom_range(0, 3) == 0));
      end

      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule